// File: doc/BRIEF.md
# Dual-Bank Next-Hop Table with Timed Changeover

This block manages the next-hop routing state of one switch in a mesh-style on-chip network. It holds two banks of next-hop entries, one per destination node. The live bank answers all route lookups. The standby bank collects route changes from a reserved control channel. When a link cost changes, for example because a component has crossed a thermal limit, a reroute trigger arrives with a network-wide timestamp. Each switch then arms a changeover for a fixed number of cycles after that stamp. Every switch computes the same changeover cycle from the same stamp, so the whole network flips banks on one cycle and never routes with a half-converged table.

A trigger first loads the standby bank with a copy of the live bank. The control updates that follow then edit only the entries that change. On the changeover cycle the live-bank select bit toggles, and the previously live bank becomes the standby bank. Each input lane chooses its output port when the head flit of a packet is routed and keeps that port for the rest of the packet. A packet that started before the changeover therefore finishes on its old route, and only packets injected after the changeover use the new bank.

Top module: `dual_table_router`

## Requirements
- R1: After a synchronous active-low reset, `act_sel` is 0, `switch_armed` is 0, and in both banks the entry for destination d holds port d mod NUM_PORTS (5 by default).
- R2: `lk_port` shows the live-bank entry for `lk_dest` combinationally, in the same cycle.
- R3: A control update (`ctl_valid`, `ctl_dest`, `ctl_port`) writes only the standby bank. Lookups on the live bank do not change as a result.
- R4: A trigger copies the whole live bank into the standby bank at that edge, which discards any earlier standby edits, and sets `switch_armed`. A control update presented in the same cycle as the trigger is applied on top of the copy.
- R5: When armed, the changeover happens at the clock edge where `cur_time` equals `trig_stamp + CONV_CYCLES` (modulo 2^TS_W). At that edge `act_sel` toggles once and `switch_armed` clears. `act_sel` does not change one edge earlier.
- R6: If no control update has arrived since the last trigger, reaching the changeover time clears `switch_armed` without toggling `act_sel`.
- R7: A trigger that arrives while armed restarts the countdown from its own stamp, clears the record of received updates and copies the live bank into the standby bank again. The earlier deadline then has no effect.
- R8: For a head flit (`flit_valid` and `flit_head` high), the lane's `route_port` is the live-bank entry for its `flit_dest` in that cycle, and `route_sel` is the current `act_sel`.
- R9: For a non-head flit, `route_port` and `route_sel` hold the values latched at that lane's last head flit. This holds across a changeover, and `flit_dest` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | TS_W | Network-wide cycle timebase |
| trig_valid | input | 1 | Reroute trigger present |
| trig_stamp | input | TS_W | Timestamp carried by the trigger |
| ctl_valid | input | 1 | Control-channel table update present |
| ctl_dest | input | DW | Destination whose entry is updated |
| ctl_port | input | PW | New next-hop port for that destination |
| lk_dest | input | DW | Lookup destination |
| lk_port | output | PW | Live-bank next hop for `lk_dest` |
| act_sel | output | 1 | Index of the live bank |
| switch_armed | output | 1 | A changeover is pending |
| flit_valid | input | NUM_IN | Per-lane flit present |
| flit_head | input | NUM_IN | Per-lane head-flit marker |
| flit_dest | input | NUM_IN*DW | Per-lane destination, lane i at bits [i*DW +: DW] |
| route_port | output | NUM_IN*PW | Per-lane chosen output port |
| route_sel | output | NUM_IN | Per-lane bank used by the current packet |

## Verification
The bench targets the changeover edge itself. It checks that the bank is still the old one with `cur_time` one step short of the deadline, and that the bank has flipped one edge later. A design that counted from trigger arrival instead of from the stamp, or that compared off by one, would flip early or late. A body flit sent right after a head that was routed just before the changeover must keep the old port, while a new head on another lane gets the new port; a design that looked up every flit would split the packet. The bench also re-triggers mid-countdown and triggers with no updates, where a design that kept the stale deadline or swapped unconditionally would flip the bank at the wrong time. It checks that standby edits made before a trigger are wiped by the copy, while an edit in the trigger cycle survives.

// File: rtl/dtr_pkg.sv
// Shared constants for the dual-bank next-hop table.
// Assumes: bank count is fixed at two (live and standby).
package dtr_pkg;
    localparam int BANKS = 2;
endpackage

// File: rtl/dtr_bank.sv
// One bank of next-hop entries, one per destination node.
// A bulk copy loads every entry from another bank; a single-entry write
// applied in the same cycle takes precedence over the copied value.
// Assumes: the caller enables copy/write only while this bank is standby.
module dtr_bank #(
    parameter int NODES     = 16,
    parameter int NUM_PORTS = 5,
    parameter int DW        = $clog2(NODES),
    parameter int PW        = $clog2(NUM_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       copy_en,
    input  logic [NODES-1:0][PW-1:0]   copy_src,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_idx,
    input  logic [PW-1:0]              wr_data,
    output logic [NODES-1:0][PW-1:0]   entries
);
    // Entry storage: reset pattern, bulk copy, then single-entry override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NODES; i++) entries[i] <= PW'(i % NUM_PORTS);
        end else begin
            for (int i = 0; i < NODES; i++) begin
                if (wr_en && (wr_idx == DW'(i)))
                    entries[i] <= wr_data;
                else if (copy_en)
                    entries[i] <= copy_src[i];
            end
        end
    end
endmodule

// File: rtl/dtr_timer.sv
// Changeover timer: arms on a trigger, fires at stamp + CONV_CYCLES on the
// shared timebase, and only if an update arrived since the last trigger.
// Assumes: the trigger arrives before its deadline has passed on cur_time.
module dtr_timer #(
    parameter int TS_W        = 16,
    parameter int CONV_CYCLES = 600
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] cur_time,
    input  logic            trig_valid,
    input  logic [TS_W-1:0] trig_stamp,
    input  logic            upd_valid,
    output logic            armed,
    output logic            swap
);
    localparam logic [TS_W-1:0] CONV = TS_W'(CONV_CYCLES);

    logic [TS_W-1:0] deadline;
    logic            got_update;
    logic            hit;

    // Deadline match and the single-cycle changeover strobe.
    always_comb begin
        hit  = armed && (cur_time == deadline);
        swap = hit && !trig_valid && got_update;
    end

    // Arm/restart on trigger, disarm at deadline, track update arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            deadline   <= '0;
            got_update <= 1'b0;
        end else if (trig_valid) begin
            armed      <= 1'b1;
            deadline   <= trig_stamp + CONV;
            got_update <= upd_valid;
        end else if (hit) begin
            armed      <= 1'b0;
            got_update <= upd_valid;
        end else if (upd_valid) begin
            got_update <= 1'b1;
        end
    end

    // R4
    arm_on_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |=> armed);
    // R7
    arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(armed)) |-> $past(trig_valid));
endmodule

// File: rtl/dtr_lane.sv
// Per-lane route holder: a head flit takes the live-bank port and bank
// index; non-head flits reuse what the last head latched.
// Assumes: a lane carries one packet at a time (no interleaving).
module dtr_lane #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          head,
    input  logic [PW-1:0] head_port,
    input  logic          head_sel,
    output logic [PW-1:0] port,
    output logic          sel
);
    logic [PW-1:0] port_q;
    logic          sel_q;

    // Capture the route decision when a head flit is routed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            sel_q  <= 1'b0;
        end else if (valid && head) begin
            port_q <= head_port;
            sel_q  <= head_sel;
        end
    end

    // Head flits use the fresh lookup, all others the held decision.
    always_comb begin
        port = (valid && head) ? head_port : port_q;
        sel  = (valid && head) ? head_sel  : sel_q;
    end

    // R9
    body_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && valid && !head) |-> ($stable(port) && $stable(sel)));
endmodule

// File: rtl/dual_table_router.sv
// Dual-bank next-hop table with a timestamp-aligned changeover.
// Control updates edit the standby bank; a trigger copies live to standby
// and arms the timer; the changeover toggles the live-bank select.
// Assumes: cur_time advances identically at every switch.
module dual_table_router #(
    parameter int NODES       = 16,
    parameter int NUM_PORTS   = 5,
    parameter int TS_W        = 16,
    parameter int CONV_CYCLES = 600,
    parameter int NUM_IN      = 2,
    parameter int DW          = $clog2(NODES),
    parameter int PW          = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TS_W-1:0]      cur_time,
    input  logic                 trig_valid,
    input  logic [TS_W-1:0]      trig_stamp,
    input  logic                 ctl_valid,
    input  logic [DW-1:0]        ctl_dest,
    input  logic [PW-1:0]        ctl_port,
    input  logic [DW-1:0]        lk_dest,
    output logic [PW-1:0]        lk_port,
    output logic                 act_sel,
    output logic                 switch_armed,
    input  logic [NUM_IN-1:0]    flit_valid,
    input  logic [NUM_IN-1:0]    flit_head,
    input  logic [NUM_IN*DW-1:0] flit_dest,
    output logic [NUM_IN*PW-1:0] route_port,
    output logic [NUM_IN-1:0]    route_sel
);
    import dtr_pkg::*;

    logic [NODES-1:0][PW-1:0] tbl [BANKS];
    logic                     swap;
    logic                     sel_next;

    dtr_timer #(.TS_W(TS_W), .CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
        .trig_valid(trig_valid), .trig_stamp(trig_stamp),
        .upd_valid(ctl_valid), .armed(switch_armed), .swap(swap)
    );

    // Live-bank index after this edge; updates target the other bank.
    always_comb sel_next = act_sel ^ swap;

    // Live-bank select register, toggled once per changeover.
    always_ff @(posedge clk) begin
        if (!rst_n) act_sel <= 1'b0;
        else        act_sel <= sel_next;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        dtr_bank #(.NODES(NODES), .NUM_PORTS(NUM_PORTS), .DW(DW), .PW(PW)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .copy_en(trig_valid && (act_sel != 1'(b))),
            .copy_src(tbl[BANKS-1-b]),
            .wr_en(ctl_valid && (sel_next != 1'(b))),
            .wr_idx(ctl_dest), .wr_data(ctl_port),
            .entries(tbl[b])
        );
    end

    // Lookup port reads the live bank.
    always_comb lk_port = tbl[act_sel][lk_dest];

    for (genvar l = 0; l < NUM_IN; l++) begin : g_lane
        logic [PW-1:0] hp;
        always_comb hp = tbl[act_sel][flit_dest[l*DW +: DW]];
        dtr_lane #(.PW(PW)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .valid(flit_valid[l]), .head(flit_head[l]),
            .head_port(hp), .head_sel(act_sel),
            .port(route_port[l*PW +: PW]), .sel(route_sel[l])
        );
    end

    // R5
    sel_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (act_sel != $past(act_sel))) |-> ($past(switch_armed) && !switch_armed));
    // R3
    live_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(lk_dest) && $stable(act_sel)) |-> $stable(lk_port));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!act_sel && !switch_armed));
endmodule

// File: tb/dual_table_router_test.sv
module dual_table_router_test;
    localparam int PERIOD = 10;
    localparam int NODES = 16, NUM_PORTS = 5, TS_W = 16, CONV = 600, NUM_IN = 2;
    localparam int DW = 4, PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TS_W-1:0] cur_time = '0;
    logic trig_valid = 1'b0;
    logic [TS_W-1:0] trig_stamp = '0;
    logic ctl_valid = 1'b0;
    logic [DW-1:0] ctl_dest = '0;
    logic [PW-1:0] ctl_port = '0;
    logic [DW-1:0] lk_dest = '0;
    logic [PW-1:0] lk_port;
    logic act_sel, switch_armed;
    logic [NUM_IN-1:0] flit_valid = '0, flit_head = '0;
    logic [NUM_IN*DW-1:0] flit_dest = '0;
    logic [NUM_IN*PW-1:0] route_port;
    logic [NUM_IN-1:0] route_sel;

    int n_chk = 0, n_bad = 0;

    // Reset-table vectors: {dest, expected port = dest mod 5}.
    localparam logic [7:0] VEC [8] = '{8'h00, 8'h11, 8'h44, 8'h50,
                                       8'h83, 8'hB1, 8'hD3, 8'hF0};

    dual_table_router uut (.*);

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        cur_time = cur_time + 1'b1;
    endtask

    task automatic look(input int d, input int exp, input string req);
        lk_dest = DW'(d);
        #1;
        check(lk_port == PW'(exp), req, lk_port, exp);
    endtask

    task automatic upd(input int d, input int p);
        ctl_valid = 1'b1; ctl_dest = DW'(d); ctl_port = PW'(p);
        cyc();
        ctl_valid = 1'b0;
    endtask

    task automatic trig(input logic [TS_W-1:0] s);
        trig_valid = 1'b1; trig_stamp = s;
        cyc();
        trig_valid = 1'b0;
    endtask

    task automatic wait_until(input logic [TS_W-1:0] t);
        while (cur_time != t) cyc();
    endtask

    initial begin
        #(PERIOD*200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [TS_W-1:0] s1, s2;
        cyc(); cyc();
        rst_n = 1'b1;
        // R1 reset state
        check(act_sel == 1'b0, "R1 act_sel", act_sel, 0);
        check(switch_armed == 1'b0, "R1 armed", switch_armed, 0);
        // R1 R2 reset table through the lookup
        foreach (VEC[i]) look(VEC[i][7:4], VEC[i][3:0], "R2 reset lookup");

        // R3: standby edit before any trigger leaves live bank alone
        upd(9, 2);
        look(9, 4, "R3 live untouched");

        // R5 stamp-based deadline (stamp lies 10 cycles in the past)
        s1 = cur_time - 16'd10;
        trig(s1);
        check(switch_armed == 1'b1, "R4 armed", switch_armed, 1);
        upd(3, 0);
        upd(7, 1);
        look(3, 3, "R3 live untouched after update");
        wait_until(s1 + 16'(CONV));
        check(act_sel == 1'b0, "R5 not early", act_sel, 0);
        // R8 head on lane0 just before the changeover
        flit_valid = 2'b01; flit_head = 2'b01; flit_dest = {4'd0, 4'd3};
        #1;
        check(route_port[2:0] == 3'd3, "R8 head old port", route_port[2:0], 3);
        cyc();
        check(act_sel == 1'b1, "R5 changeover", act_sel, 1);
        check(switch_armed == 1'b0, "R5 disarm", switch_armed, 0);
        // R9 body flit keeps old route; R8 new head on lane1 uses new bank
        flit_valid = 2'b11; flit_head = 2'b10; flit_dest = {4'd3, 4'd7};
        #1;
        check(route_port[2:0] == 3'd3, "R9 body port", route_port[2:0], 3);
        check(route_sel[0] == 1'b0, "R9 body sel", route_sel[0], 0);
        check(route_port[5:3] == 3'd0, "R8 new head port", route_port[5:3], 0);
        check(route_sel[1] == 1'b1, "R8 new head sel", route_sel[1], 1);
        flit_valid = '0; flit_head = '0;
        look(3, 0, "R5 new entry 3");
        look(7, 1, "R5 new entry 7");
        look(9, 4, "R4 pre-trigger edit discarded");
        look(5, 0, "R4 copied entry");

        // R7 restart mid-countdown
        s1 = cur_time;
        trig(s1);
        repeat (300) cyc();
        upd(2, 4);
        s2 = cur_time;
        trig(s2);
        upd(4, 1);
        wait_until(s1 + 16'(CONV));
        cyc();
        check(act_sel == 1'b1, "R7 old deadline ignored", act_sel, 1);
        wait_until(s2 + 16'(CONV));
        cyc();
        check(act_sel == 1'b0, "R7 new deadline", act_sel, 0);
        look(2, 2, "R7 recopy discards edit");
        look(4, 1, "R7 edit after restart");
        look(3, 0, "R7 copied prior route");

        // R6 no update since trigger: disarm without changeover
        s1 = cur_time;
        trig(s1);
        wait_until(s1 + 16'(CONV));
        cyc();
        check(act_sel == 1'b0, "R6 no swap", act_sel, 0);
        check(switch_armed == 1'b0, "R6 disarmed", switch_armed, 0);

        // R4 update in the trigger cycle lands on the copy
        s1 = cur_time;
        ctl_valid = 1'b1; ctl_dest = 4'd6; ctl_port = 3'd3;
        trig(s1);
        ctl_valid = 1'b0;
        wait_until(s1 + 16'(CONV));
        cyc();
        check(act_sel == 1'b1, "R4 swap with same-cycle update", act_sel, 1);
        look(6, 3, "R4 same-cycle update");
        look(4, 1, "R4 copy of live");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule